// File: doc/BRIEF.md
# Interrupt Priority Selector with Nested Acknowledge

This block looks at a row of interrupt sources. Each source brings an enable bit, a pending bit and an 8-bit priority. Every cycle it picks the best candidate among the sources that are both enabled and pending, and it raises a request when that candidate would preempt the source now being serviced. Pending state is kept outside the block. The block only asks for a pending bit to be cleared, through a one-cycle pulse.

An acknowledge strobe returns the current winner in the same cycle and makes it the running source. The block remembers which source was running before, so interrupts can nest. An end-of-interrupt naming the running source restores the source that it preempted. The value 1023 is reserved as the spurious / idle ID.

Top module: `irq_prio_ack`

## Requirements
- R1: A source takes part in selection only when its enable bit and its pending bit are both 1.
- R2: Among qualifying sources, the one with the numerically smallest priority value wins. On a tie, the lowest source index wins. Priority 255 still beats "no candidate". Source i's priority is `srcPrio[i*8 +: 8]`.
- R3: When no source qualifies, `bestId` is 1023 and `irqReq` is 0.
- R4: `irqReq` is 1 exactly when a winner exists and its priority is strictly smaller than the running source's priority. When idle (running ID 1023), any winner raises `irqReq`.
- R5: An acknowledge with a winner returns the winner on `ackId` in the strobe cycle. In that same cycle it pulses `clrPendValid` with `clrPendId` equal to the winner. `runningId` equals the winner from the next cycle on.
- R6: An acknowledge with no winner returns 1023, gives no clear pulse and leaves `runningId` unchanged.
- R7: An end-of-interrupt whose ID equals `runningId` restores `runningId` to the ID that was running when that source was acknowledged. Nesting unwinds in reverse order.
- R8: An end-of-interrupt while `runningId` is 1023 is ignored.
- R9: An end-of-interrupt whose ID differs from `runningId` is ignored.
- R10: When acknowledge and end-of-interrupt are strobed in the same cycle, the acknowledge is performed and the end-of-interrupt is dropped.
- R11: After reset `runningId` is 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| srcEnable | input | NUM_SRC | Per-source enable |
| srcPending | input | NUM_SRC | Per-source effective pending state |
| srcPrio | input | NUM_SRC*8 | Packed priorities, source i at bits i*8+:8 |
| ackStrobe | input | 1 | Acknowledge request |
| eoiStrobe | input | 1 | End-of-interrupt request |
| eoiId | input | 10 | ID being completed |
| irqReq | output | 1 | Preempting interrupt available |
| bestId | output | 10 | Current winner, 1023 if none |
| ackId | output | 10 | Acknowledge result (1023 when no strobe or no winner) |
| clrPendValid | output | 1 | One-cycle clear-pending pulse |
| clrPendId | output | 10 | Source whose pending bit should be cleared |
| runningId | output | 10 | Source currently being serviced, 1023 when idle |

## Verification
The selector is tried with the following patterns:
- sources that are enabled but not pending, and pending but not enabled, next to a single qualifying source; this separates the qualifying gate from the priority compare;
- equal priorities at non-adjacent indices; this separates the tie rule from the compare;
- all candidates at priority 255; this shows that the idle sentinel sits above every real priority.

The preemption test then moves a candidate's priority from equal to one below the running source. This isolates the strict compare. Nested acknowledges, a mismatched completion, completion while idle, and a coincident acknowledge plus completion tell the link restore apart from a plain clear of the running ID.

// File: rtl/irq_prio_ack_pkg.sv
package irq_prio_ack_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPUR_ID = 10'd1023;

  typedef struct packed {
    logic            push;
    logic            pop;
    logic [ID_W-1:0] pushId;
  } strobe_t;
endpackage

// File: rtl/irq_prio_scan.sv
module irq_prio_scan
  import irq_prio_ack_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 8
) (
  input  logic [NUM_SRC-1:0]  srcEnable,
  input  logic [NUM_SRC-1:0]  srcPending,
  input  logic [PRIO_W-1:0]   prioArr [NUM_SRC],
  input  logic [ID_W-1:0]     runningId,
  output logic [ID_W-1:0]     bestId,
  output logic                irqReq
);
  localparam int KEY_W = PRIO_W + 1;
  localparam logic [KEY_W-1:0] SENTINEL = KEY_W'(1) << PRIO_W;

  logic [KEY_W-1:0] bestKey;
  logic [KEY_W-1:0] runKey;

  always_comb begin
    bestKey = SENTINEL;
    bestId  = SPUR_ID;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (srcEnable[i] && srcPending[i] && ({1'b0, prioArr[i]} < bestKey)) begin
        bestKey = {1'b0, prioArr[i]};
        bestId  = ID_W'(i);
      end
    end
  end

  always_comb begin
    runKey = SENTINEL;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (runningId == ID_W'(i)) runKey = {1'b0, prioArr[i]};
    end
  end

  assign irqReq = (bestId != SPUR_ID) && (bestKey < runKey);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_ack_pkg::*;
(
  input  logic            ackStrobe,
  input  logic            eoiStrobe,
  input  logic [ID_W-1:0] eoiId,
  input  logic [ID_W-1:0] bestId,
  input  logic [ID_W-1:0] runningId,
  output strobe_t         strb,
  output logic [ID_W-1:0] ackId,
  output logic            clrPendValid,
  output logic [ID_W-1:0] clrPendId
);
  logic winValid;

  assign winValid = (bestId != SPUR_ID);

  always_comb begin
    strb.push   = ackStrobe && winValid;
    strb.pushId = bestId;
    strb.pop    = eoiStrobe && !ackStrobe && (runningId != SPUR_ID) && (eoiId == runningId);
  end

  assign ackId        = ackStrobe ? bestId : SPUR_ID;
  assign clrPendValid = strb.push;
  assign clrPendId    = strb.push ? bestId : SPUR_ID;
endmodule

// File: rtl/irq_prio_state.sv
module irq_prio_state
  import irq_prio_ack_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  strobe_t         strb,
  output logic [ID_W-1:0] runningId
);
  logic [ID_W-1:0] prevId [NUM_SRC];
  logic [ID_W-1:0] prevSel;

  always_comb begin
    prevSel = SPUR_ID;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (runningId == ID_W'(i)) prevSel = prevId[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runningId <= SPUR_ID;
      for (int i = 0; i < NUM_SRC; i++) prevId[i] <= SPUR_ID;
    end else if (strb.push) begin
      runningId <= strb.pushId;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (strb.pushId == ID_W'(i)) prevId[i] <= runningId;
      end
    end else if (strb.pop) begin
      runningId <= prevSel;
    end
  end

  assert_push_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.push |=> runningId == $past(strb.pushId));
  assert_hold_without_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.push && !strb.pop) |=> $stable(runningId));
  assert_no_pop_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.pop |-> runningId != SPUR_ID);
endmodule

// File: rtl/irq_prio_ack.sv
module irq_prio_ack
  import irq_prio_ack_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        srcEnable,
  input  logic [NUM_SRC-1:0]        srcPending,
  input  logic [NUM_SRC*PRIO_W-1:0] srcPrio,
  input  logic                      ackStrobe,
  input  logic                      eoiStrobe,
  input  logic [9:0]                eoiId,
  output logic                      irqReq,
  output logic [9:0]                bestId,
  output logic [9:0]                ackId,
  output logic                      clrPendValid,
  output logic [9:0]                clrPendId,
  output logic [9:0]                runningId
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [PRIO_W-1:0] prioArr [NUM_SRC];
  strobe_t           strb;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
    assign prioArr[g] = srcPrio[g*PRIO_W +: PRIO_W];
  end

  irq_prio_scan #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_scan (
    .srcEnable(srcEnable), .srcPending(srcPending), .prioArr(prioArr),
    .runningId(runningId), .bestId(bestId), .irqReq(irqReq)
  );

  irq_prio_ctrl u_ctrl (
    .ackStrobe(ackStrobe), .eoiStrobe(eoiStrobe), .eoiId(eoiId),
    .bestId(bestId), .runningId(runningId), .strb(strb),
    .ackId(ackId), .clrPendValid(clrPendValid), .clrPendId(clrPendId)
  );

  irq_prio_state #(.NUM_SRC(NUM_SRC)) u_state (
    .clk(clk), .rst_n(rst_n), .strb(strb), .runningId(runningId)
  );

  assert_winner_qualified_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bestId != SPUR_ID) |-> (srcEnable[bestId[IDX_W-1:0]] && srcPending[bestId[IDX_W-1:0]]));
  assert_req_needs_winner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> bestId != SPUR_ID);
  assert_clear_matches_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clrPendValid |=> runningId == $past(clrPendId));
endmodule

// File: tb/irq_prio_ack_tb.sv
module irq_prio_ack_tb;
  localparam int N = 16;
  localparam logic [9:0] SPUR = 10'd1023;

  logic clk = 0;
  logic rst_n = 0;
  logic [N-1:0] srcEnable = '0;
  logic [N-1:0] srcPending = '0;
  logic [N*8-1:0] srcPrio = '0;
  logic ackStrobe = 0, eoiStrobe = 0;
  logic [9:0] eoiId = '0;
  logic irqReq, clrPendValid;
  logic [9:0] bestId, ackId, clrPendId, runningId;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_prio_ack #(.NUM_SRC(N), .PRIO_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .srcEnable(srcEnable), .srcPending(srcPending),
    .srcPrio(srcPrio), .ackStrobe(ackStrobe), .eoiStrobe(eoiStrobe), .eoiId(eoiId),
    .irqReq(irqReq), .bestId(bestId), .ackId(ackId), .clrPendValid(clrPendValid),
    .clrPendId(clrPendId), .runningId(runningId)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setSrc(int i, bit en, bit pend, int prio);
    srcEnable[i] = en;
    srcPending[i] = pend;
    srcPrio[i*8 +: 8] = 8'(prio);
  endtask

  task automatic resetAll();
    @(negedge clk);
    rst_n = 0; srcEnable = '0; srcPending = '0; srcPrio = '0;
    ackStrobe = 0; eoiStrobe = 0; eoiId = '0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // acknowledge; check same-cycle result, then registered running ID
  task automatic doAck(string req, int expId, int expRun);
    @(negedge clk);
    ackStrobe = 1;
    #1;
    check({req, " ackId"}, ackId, expId);
    check({req, " clrPendValid"}, clrPendValid, expId != SPUR);
    if (expId != SPUR) check({req, " clrPendId"}, clrPendId, expId);
    @(posedge clk); #1;
    ackStrobe = 0;
    if (expId != SPUR) srcPending[expId] = 0;
    check({req, " runningId"}, runningId, expRun);
  endtask

  task automatic doEoi(string req, int id, int expRun);
    @(negedge clk);
    eoiStrobe = 1; eoiId = 10'(id);
    @(posedge clk); #1;
    eoiStrobe = 0;
    check({req, " runningId"}, runningId, expRun);
  endtask

  task automatic testReset();
    resetAll();
    check("R11 reset running", runningId, SPUR);
    check("R3 none bestId", bestId, SPUR);
    check("R3 none irqReq", irqReq, 0);
  endtask

  task automatic testQualify();
    resetAll();
    setSrc(3, 0, 1, 0);
    setSrc(5, 1, 0, 0);
    #1;
    check("R1 no qualifier", bestId, SPUR);
    setSrc(9, 1, 1, 50);
    #1;
    check("R1 only qualified wins", bestId, 9);
  endtask

  task automatic testPriority();
    resetAll();
    setSrc(2, 1, 1, 40); setSrc(11, 1, 1, 20); setSrc(7, 1, 1, 20);
    #1;
    check("R2 lowest value, tie lowest id", bestId, 7);
    setSrc(2, 1, 1, 255); setSrc(11, 0, 0, 0); setSrc(7, 0, 0, 0); setSrc(6, 1, 1, 255);
    #1;
    check("R2 prio 255 beats sentinel", bestId, 2);
    check("R4 idle any winner requests", irqReq, 1);
  endtask

  task automatic testPreempt();
    resetAll();
    setSrc(1, 1, 1, 255);
    doAck("R5 ack src1", 1, 1);
    setSrc(2, 1, 1, 255);
    #1;
    check("R4 equal prio no request", irqReq, 0);
    setSrc(2, 1, 1, 254);
    #1;
    check("R4 lower prio requests", irqReq, 1);
  endtask

  task automatic testSpurious();
    resetAll();
    doAck("R6 idle ack", SPUR, SPUR);
    setSrc(4, 1, 1, 30);
    doAck("R5 ack src4", 4, 4);
    doAck("R6 ack none while running", SPUR, 4);
  endtask

  task automatic testNesting();
    resetAll();
    setSrc(4, 1, 1, 30);
    doAck("R5 first", 4, 4);
    setSrc(8, 1, 1, 10);
    #1;
    check("R4 nested request", irqReq, 1);
    doAck("R5 nested", 8, 8);
    doEoi("R9 wrong id", 4, 8);
    doEoi("R7 restore outer", 8, 4);
    doEoi("R7 restore idle", 4, SPUR);
    doEoi("R8 idle eoi 1023", SPUR, SPUR);
    doEoi("R8 idle eoi 0", 0, SPUR);
  endtask

  task automatic testCollide();
    resetAll();
    setSrc(4, 1, 1, 30);
    doAck("R5 base", 4, 4);
    setSrc(8, 1, 1, 10);
    @(negedge clk);
    ackStrobe = 1; eoiStrobe = 1; eoiId = 10'd4;
    #1;
    check("R10 ack taken", ackId, 8);
    @(posedge clk); #1;
    ackStrobe = 0; eoiStrobe = 0; srcPending[8] = 0;
    check("R10 running after collide", runningId, 8);
    doEoi("R10 link kept", 8, 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testQualify();
    testPriority();
    testPreempt();
    testSpurious();
    testNesting();
    testCollide();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule